// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block is the retirement queue of a speculative core that executes out of order. Each instruction claims a slot when it issues, in program order, and the slot number is handed back at once so it can travel with the instruction as its destination tag. Functional units broadcast finished results with that tag. The buffer stores the value and marks the entry complete, so results may arrive in any order.

Only the oldest entry can retire, and only once its result is present. At most one entry retires per cycle. On retirement the entry's destination and value go out on the commit port, where a register write or a store updates architectural state. Because retirement follows program order, faults are precise. An entry flagged with an exception is not committed. Instead, when it reaches the head it discards itself and every younger entry. A branch flagged as mispredicted is committed and then discards every younger entry.

After either kind of discard, a one-cycle recovery state drives a redirect pulse. A cause bit tells a fault from a misprediction. The controller has two states. OPEN is the normal state, in which slots are allocated, results are captured and entries retire. RECOVER lasts exactly one cycle, during which the redirect is raised and allocation is refused. The transitions are:

- OPEN to RECOVER, when the head discards the buffer.
- RECOVER to OPEN, unconditionally on the next edge.
- OPEN to OPEN, in every other case.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `commit_valid` and `redirect` are 0.
- R2: Accepted allocations receive tags in increasing order. The tag wraps from DEPTH-1 back to 0. An allocation is accepted in a cycle where `alloc_valid` and `alloc_ready` are both 1.
- R3: While DEPTH entries are outstanding, `alloc_ready` is 0 and a request is not taken.
- R4: A writeback captures its value and flags into the entry named by `wb_tag`. A writeback to a tag that holds no allocated entry is ignored, and it does not complete a later occupant of that slot.
- R5: Entries may complete in any order, but they commit strictly oldest first. An entry does not commit before its result is present, and nothing commits while the buffer is empty.
- R6: At most one entry commits per cycle. `commit_valid` is raised for one cycle carrying the entry's kind, destination and value. The kind encodings are 00 for a register write, 01 for a store and 10 for a branch.
- R7: A branch (kind 10) completed with `wb_mispredict`=1 is committed. Every younger entry is then discarded, and in the following cycle `redirect` is 1 for exactly one cycle with `redirect_cause`=0.
- R8: An entry completed with `wb_exception`=1 is not committed when it reaches the head. It and every younger entry are discarded, and in the following cycle `redirect` is 1 for one cycle with `redirect_cause`=1.
- R9: During the redirect cycle `alloc_ready` is 0 and the buffer is empty. Afterwards, allocation restarts at tag 0.
- R10: The mispredict flag on an entry that is not a branch has no effect. The entry commits normally and no redirect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 2 | Kind of issuing instruction (00 reg, 01 store, 10 branch) |
| alloc_dest | input | DEST_W | Destination register or store target |
| alloc_ready | output | 1 | Slot available this cycle |
| alloc_tag | output | TAG_W | Tag given to the issuing instruction |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Branch resolved as mispredicted |
| wb_exception | input | 1 | Instruction raised a fault |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_kind | output | 2 | Kind of retiring entry |
| commit_dest | output | DEST_W | Destination of retiring entry |
| commit_value | output | DATA_W | Value of retiring entry |
| redirect | output | 1 | One-cycle pulse after a discard |
| redirect_cause | output | 1 | 0 = misprediction, 1 = fault |

## Verification
The first directed pattern completes results in reverse issue order. A buffer that retires whatever completes first can then be told apart from one that waits on the head. Filling every slot from a mid-queue start checks the full refusal and the tag wrap together. A write to an empty slot that is later reused separates proper capture from stale completion. Separate patterns end in a mispredicted branch, a faulting store and a mispredict-flagged register write. They distinguish committed discard, uncommitted discard and no discard, with the younger completed entries showing whether the discard was complete.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        K_REG    = 2'b00,
        K_STORE  = 2'b01,
        K_BRANCH = 2'b10
    } kind_e;

    typedef enum logic {
        ST_OPEN    = 1'b0,
        ST_RECOVER = 1'b1
    } rob_state_e;
endpackage

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int DEST_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              alloc_we,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  kind_e             alloc_kind,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              wb_we,
    input  logic [TAG_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_mis,
    input  logic              wb_exc,
    input  logic              free_we,
    input  logic [TAG_W-1:0]  free_idx,
    input  logic [TAG_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_ready,
    output kind_e             rd_kind,
    output logic [DEST_W-1:0] rd_dest,
    output logic [DATA_W-1:0] rd_value,
    output logic              rd_mis,
    output logic              rd_exc
);
    logic              valid_q [DEPTH];
    logic              ready_q [DEPTH];
    kind_e             kind_q  [DEPTH];
    logic [DEST_W-1:0] dest_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];
    logic              mis_q   [DEPTH];
    logic              exc_q   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_alloc, hit_wb, hit_free;
        assign hit_alloc = alloc_we && (alloc_idx == TAG_W'(g));
        assign hit_wb    = wb_we && (wb_idx == TAG_W'(g)) && valid_q[g] && !ready_q[g];
        assign hit_free  = free_we && (free_idx == TAG_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                ready_q[g] <= 1'b0;
                kind_q[g]  <= K_REG;
                dest_q[g]  <= '0;
                value_q[g] <= '0;
                mis_q[g]   <= 1'b0;
                exc_q[g]   <= 1'b0;
            end else if (clear_all) begin
                valid_q[g] <= 1'b0;
                ready_q[g] <= 1'b0;
            end else begin
                if (hit_free) begin
                    valid_q[g] <= 1'b0;
                    ready_q[g] <= 1'b0;
                end
                if (hit_alloc) begin
                    valid_q[g] <= 1'b1;
                    ready_q[g] <= 1'b0;
                    kind_q[g]  <= alloc_kind;
                    dest_q[g]  <= alloc_dest;
                    mis_q[g]   <= 1'b0;
                    exc_q[g]   <= 1'b0;
                end
                if (hit_wb) begin
                    ready_q[g] <= 1'b1;
                    value_q[g] <= wb_value;
                    mis_q[g]   <= wb_mis;
                    exc_q[g]   <= wb_exc;
                end
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_ready = ready_q[rd_idx];
    assign rd_kind  = kind_q[rd_idx];
    assign rd_dest  = dest_q[rd_idx];
    assign rd_value = value_q[rd_idx];
    assign rd_mis   = mis_q[rd_idx];
    assign rd_exc   = exc_q[rd_idx];
endmodule

// File: rtl/rob_fsm.sv
module rob_fsm
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req,
    input  logic flush_cause,
    output logic open,
    output logic redirect,
    output logic redirect_cause
);
    rob_state_e state_q, state_d;
    logic       cause_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:    if (flush_req) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_OPEN;
            default:    state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cause_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (flush_req) cause_q <= flush_cause;
        end
    end

    always_comb begin
        open           = 1'b0;
        redirect       = 1'b0;
        redirect_cause = 1'b0;
        unique case (state_q)
            ST_OPEN:    open = 1'b1;
            ST_RECOVER: begin
                redirect       = 1'b1;
                redirect_cause = cause_q;
            end
            default:    open = 1'b0;
        endcase
    end
endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DEST_W = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [DEST_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_mispredict,
    input  logic              wb_exception,
    output logic              commit_valid,
    output logic [1:0]        commit_kind,
    output logic [DEST_W-1:0] commit_dest,
    output logic [DATA_W-1:0] commit_value,
    output logic              redirect,
    output logic              redirect_cause
);
    localparam int CNT_W = TAG_W + 1;

    logic [TAG_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic             full, fire, flush_now, alloc_fire, fsm_open;
    logic             rd_valid, rd_ready, rd_mis, rd_exc;
    kind_e            rd_kind;
    logic [DEST_W-1:0] rd_dest;
    logic [DATA_W-1:0] rd_value;

    function automatic logic [TAG_W-1:0] step_ptr(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    rob_slots #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .DEST_W(DEST_W), .DATA_W(DATA_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (flush_now),
        .alloc_we   (alloc_fire),
        .alloc_idx  (tail_q),
        .alloc_kind (kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .wb_we      (wb_valid),
        .wb_idx     (wb_tag),
        .wb_value   (wb_value),
        .wb_mis     (wb_mispredict),
        .wb_exc     (wb_exception),
        .free_we    (fire),
        .free_idx   (head_q),
        .rd_idx     (head_q),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_kind    (rd_kind),
        .rd_dest    (rd_dest),
        .rd_value   (rd_value),
        .rd_mis     (rd_mis),
        .rd_exc     (rd_exc)
    );

    rob_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_req      (flush_now),
        .flush_cause    (rd_exc),
        .open           (fsm_open),
        .redirect       (redirect),
        .redirect_cause (redirect_cause)
    );

    assign full        = (count_q == CNT_W'(DEPTH));
    assign fire        = rd_valid && rd_ready;
    assign flush_now   = fire && (rd_exc || (rd_kind == K_BRANCH && rd_mis));
    assign alloc_ready = fsm_open && !full && !flush_now;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q;

    assign commit_valid = fire && !rd_exc;
    assign commit_kind  = rd_kind;
    assign commit_dest  = rd_dest;
    assign commit_value = rd_value;

    always_ff @(posedge clk) begin
        if (!rst_n || flush_now) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (fire)       head_q <= step_ptr(head_q);
            if (alloc_fire) tail_q <= step_ptr(tail_q);
            unique case ({alloc_fire, fire})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             commit_valid,
    input logic             redirect,
    input logic [TAG_W:0]   count
);
    // R2
    tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=>
        (alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(alloc_tag) + 1'b1)));

    // R3
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == (TAG_W + 1)'(DEPTH)) |-> !alloc_ready);

    // R5
    empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !commit_valid);

    // R7
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R9
    recover_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (!alloc_ready && count == '0 && !commit_valid));
endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_tag    (alloc_tag),
    .commit_valid (commit_valid),
    .redirect     (redirect),
    .count        (count_q)
);

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;
    localparam int DEPTH  = 8;
    localparam int DEST_W = 5;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [1:0]        alloc_kind = 2'b00;
    logic [DEST_W-1:0] alloc_dest = '0;
    logic              alloc_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic              wb_valid = 1'b0;
    logic [TAG_W-1:0]  wb_tag = '0;
    logic [DATA_W-1:0] wb_value = '0;
    logic              wb_mispredict = 1'b0;
    logic              wb_exception = 1'b0;
    logic              commit_valid;
    logic [1:0]        commit_kind;
    logic [DEST_W-1:0] commit_dest;
    logic [DATA_W-1:0] commit_value;
    logic              redirect;
    logic              redirect_cause;

    int errors = 0;
    int checks = 0;
    int n_commit = 0;
    int n_redir = 0;
    int last_cause = -1;
    int ready_in_redir = 0;
    int log_kind [64];
    int log_dest [64];
    int log_val  [64];
    int cycles = 0;

    always #2.5 clk = ~clk;

    rob_top #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) dut (.*);

    always @(negedge clk) begin
        cycles++;
        if (rst_n && commit_valid) begin
            log_kind[n_commit % 64] = int'(commit_kind);
            log_dest[n_commit % 64] = int'(commit_dest);
            log_val[n_commit % 64]  = int'(commit_value);
            n_commit++;
        end
        if (rst_n && redirect) begin
            n_redir++;
            last_cause = int'(redirect_cause);
            if (alloc_ready) ready_in_redir++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(input int kind, input int dest, output int tag, output int ok);
        alloc_valid = 1'b1;
        alloc_kind  = 2'(kind);
        alloc_dest  = DEST_W'(dest);
        #1;
        ok  = int'(alloc_ready);
        tag = int'(alloc_tag);
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_wb(input int tag, input int val, input bit mis, input bit exc);
        wb_valid      = 1'b1;
        wb_tag        = TAG_W'(tag);
        wb_value      = DATA_W'(val);
        wb_mispredict = mis;
        wb_exception  = exc;
        @(negedge clk);
        wb_valid      = 1'b0;
        wb_mispredict = 1'b0;
        wb_exception  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", int'(alloc_ready), 1);
        chk(alloc_tag == '0, "R1", "alloc_tag", int'(alloc_tag), 0);
        chk(commit_valid == 1'b0, "R1", "commit_valid", int'(commit_valid), 0);
        chk(redirect == 1'b0, "R1", "redirect", int'(redirect), 0);
    endtask

    task automatic t_in_order();
        int tag, ok, base;
        base = n_commit;
        for (int i = 0; i < 3; i++) begin
            do_alloc(0, i + 1, tag, ok);
            chk(ok == 1 && tag == i, "R2", "tag in order", tag, i);
        end
        do_wb(2, 32'hC0, 0, 0);
        do_wb(1, 32'hB0, 0, 0);
        idle(2);
        chk(n_commit == base, "R5", "no commit before head ready", n_commit - base, 0);
        do_wb(0, 32'hA0, 0, 0);
        idle(4);
        chk(n_commit == base + 3, "R6", "commit count", n_commit - base, 3);
        for (int i = 0; i < 3; i++) begin
            chk(log_dest[(base + i) % 64] == i + 1, "R5", "commit order dest", log_dest[(base + i) % 64], i + 1);
            chk(log_val[(base + i) % 64] == 32'hA0 + 16 * i, "R6", "commit value", log_val[(base + i) % 64], 32'hA0 + 16 * i);
        end
    endtask

    task automatic t_full_wrap();
        int tag, ok, base;
        base = n_commit;
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(0, 10 + i, tag, ok);
            chk(ok == 1 && tag == (3 + i) % DEPTH, "R2", "wrapped tag", tag, (3 + i) % DEPTH);
        end
        do_alloc(0, 30, tag, ok);
        chk(ok == 0, "R3", "refused while full", ok, 0);
        for (int i = DEPTH - 1; i >= 0; i--) do_wb((3 + i) % DEPTH, 100 + i, 0, 0);
        idle(DEPTH + 3);
        chk(n_commit == base + DEPTH, "R5", "full drain count", n_commit - base, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            chk(log_val[(base + i) % 64] == 100 + i, "R5", "drain order", log_val[(base + i) % 64], 100 + i);
        chk(log_dest[(base + 7) % 64] == 17, "R6", "last dest", log_dest[(base + 7) % 64], 17);
    endtask

    task automatic t_stale_wb();
        int tag, ok, base;
        base = n_commit;
        do_wb(4, 55, 0, 0);
        do_alloc(0, 20, tag, ok);
        chk(tag == 3, "R4", "tag a", tag, 3);
        do_alloc(0, 21, tag, ok);
        chk(tag == 4, "R4", "tag b", tag, 4);
        do_wb(3, 66, 0, 0);
        idle(4);
        chk(n_commit == base + 1, "R4", "stale write ignored", n_commit - base, 1);
        chk(log_val[base % 64] == 66, "R4", "captured value", log_val[base % 64], 66);
        do_wb(4, 77, 0, 0);
        idle(3);
        chk(n_commit == base + 2, "R4", "later completion", n_commit - base, 2);
        chk(log_val[(base + 1) % 64] == 77, "R4", "fresh value not stale", log_val[(base + 1) % 64], 77);
    endtask

    task automatic t_mispredict();
        int tag, ok, base, rbase;
        base = n_commit;
        rbase = n_redir;
        do_alloc(2, 0, tag, ok);
        chk(tag == 5, "R7", "branch tag", tag, 5);
        do_alloc(0, 6, tag, ok);
        do_alloc(0, 7, tag, ok);
        do_wb(7, 700, 0, 0);
        do_wb(6, 600, 0, 0);
        do_wb(5, 500, 1, 0);
        idle(5);
        chk(n_commit == base + 1, "R7", "only branch committed", n_commit - base, 1);
        chk(log_kind[base % 64] == 2, "R7", "committed kind", log_kind[base % 64], 2);
        chk(n_redir == rbase + 1, "R7", "one redirect cycle", n_redir - rbase, 1);
        chk(last_cause == 0, "R7", "redirect cause", last_cause, 0);
        chk(ready_in_redir == 0, "R9", "alloc_ready during redirect", ready_in_redir, 0);
        chk(alloc_tag == '0 && alloc_ready, "R9", "tag restart", int'(alloc_tag), 0);
    endtask

    task automatic t_exception();
        int tag, ok, base, rbase;
        base = n_commit;
        rbase = n_redir;
        do_alloc(1, 9, tag, ok);
        chk(tag == 0, "R8", "store tag", tag, 0);
        do_alloc(0, 3, tag, ok);
        do_wb(1, 11, 0, 0);
        do_wb(0, 22, 0, 1);
        idle(5);
        chk(n_commit == base, "R8", "faulting entry not committed", n_commit - base, 0);
        chk(n_redir == rbase + 1, "R8", "redirect count", n_redir - rbase, 1);
        chk(last_cause == 1, "R8", "redirect cause", last_cause, 1);
        chk(alloc_tag == '0, "R9", "tag restart after fault", int'(alloc_tag), 0);
    endtask

    task automatic t_flag_ignored();
        int tag, ok, base, rbase;
        base = n_commit;
        rbase = n_redir;
        do_alloc(0, 4, tag, ok);
        do_alloc(1, 7, tag, ok);
        do_wb(0, 123, 1, 0);
        do_wb(1, 456, 0, 0);
        idle(4);
        chk(n_commit == base + 2, "R10", "both committed", n_commit - base, 2);
        chk(log_val[base % 64] == 123, "R10", "flagged reg value", log_val[base % 64], 123);
        chk(n_redir == rbase, "R10", "no redirect", n_redir - rbase, 0);
        chk(log_kind[(base + 1) % 64] == 1, "R6", "store kind", log_kind[(base + 1) % 64], 1);
        chk(log_dest[(base + 1) % 64] == 7, "R6", "store dest", log_dest[(base + 1) % 64], 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        @(negedge clk);
        t_in_order();
        t_full_wrap();
        t_stale_wb();
        t_mispredict();
        t_exception();
        t_flag_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule